// File: doc/BRIEF.md
# Decode-Stage Constant Accumulator

This block sits in an in-order decode stage and turns a single 32-bit constant-load instruction into a 64-bit constant. The constant is built in a private accumulator, so no register-file read port is needed. A full load sets the accumulator to a sign-extended 17-bit value. A partial load shifts the accumulator up by 16 bits and places a new 16-bit chunk in the low half. A wide constant is therefore built from one full load followed by up to three partial loads.

Each accepted load can also issue a register-file write of the new accumulator value. Destination index zero means "update the accumulator only, do not write". In the same cycle as the write, a forward copy of the value goes out to an execution unit. Instructions with any other opcode pass by without touching the accumulator. This lets other work be interleaved between the loads that build one constant.

Top module: `const_accum_decoder`

## Requirements
- R1: After reset, `wr_en` and `fwd_valid` are low, `wr_data` and `fwd_data` are zero, and the accumulator holds zero, so a partial load issued first yields just its 16-bit chunk.
- R2: The instruction fields are: opcode in bits [31:24], which must equal the parameter `OPCODE` (default 8'hC5); the partial flag P in bit 23; the sign bit S in bit 22; the 16-bit chunk in bits [21:6]; the destination index in bits [5:0].
- R3: A load with P=0 sets the accumulator to the 17-bit value {S, chunk}, sign-extended to 64 bits.
- R4: A load with P=1 sets the accumulator to (old accumulator << 16) | chunk, with S having no effect.
- R5: A load whose destination index is 0 updates the accumulator but raises no write.
- R6: A load accepted at a clock edge with a nonzero destination index makes `wr_en` high for exactly the following cycle. In that cycle `wr_idx` equals the index and `wr_data` equals the new accumulator value.
- R7: A cycle with `insn_valid` low, or with a different opcode, leaves the accumulator unchanged and gives `wr_en` low with `wr_data` zero in the next cycle.
- R8: `fwd_valid` and `fwd_data` equal `wr_en` and `wr_data` in every cycle.
- R9: Loads issued on consecutive cycles are each applied in order, with no lost or stalled instruction.
- R10: The sequence full 0x7777 to index 0, partial 0x33bb to index 0, partial 0x1919 to index 42 gives exactly one write: 0x0000777733bb1919 to index 42.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn | input | 32 | Instruction word |
| wr_en | output | 1 | Register-file write request |
| wr_idx | output | 6 | Register index to write |
| wr_data | output | 64 | Value to write |
| fwd_valid | output | 1 | Forwarded value is valid |
| fwd_data | output | 64 | Value forwarded to an execution unit |

## Verification
The bench targets the sign extension at the 17-bit edge. A chunk of 0x0001 with S set must give 0xFFFFFFFFFFFF0001, and the same chunk with S clear must stay positive. A design that extends from bit 15, or that ignores S, shows a wrong upper half. Partial loads are given S=1 and are run across a negative accumulator; an implementation that lets S leak in, or that rotates instead of shifting, gives a wrong low or high word. Index 0 and index 63 are both exercised, along with stray opcodes and an invalid matching word placed between loads. A design that writes on index 0, or that lets ignored words disturb the accumulator, shows an extra write or a corrupted later constant. A reset in the middle of a sequence must clear the accumulator, which is seen through the next partial load.

// File: rtl/const_accum_decoder.sv
module const_accum_decoder #(
  parameter logic [7:0] OPCODE = 8'hC5,
  parameter int DATA_W = 64,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  input  logic [31:0]       insn,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic              fwd_valid,
  output logic [DATA_W-1:0] fwd_data
);
  localparam int IMM_LO = IDX_W;
  localparam int S_BIT  = IMM_LO + IMM_W;
  localparam int P_BIT  = S_BIT + 1;
  localparam int OP_LO  = P_BIT + 1;

  logic [DATA_W-1:0] acc, acc_nx;
  logic              hit, is_p, s_bit, do_wr;
  logic [IMM_W-1:0]  imm;
  logic [IDX_W-1:0]  dst;

  assign hit   = insn_valid && (insn[OP_LO+7:OP_LO] == OPCODE);
  assign is_p  = insn[P_BIT];
  assign s_bit = insn[S_BIT];
  assign imm   = insn[S_BIT-1:IMM_LO];
  assign dst   = insn[IDX_W-1:0];
  assign do_wr = hit && (dst != '0);

  assign acc_nx = is_p ? {acc[DATA_W-IMM_W-1:0], imm}
                       : {{(DATA_W-IMM_W-1){s_bit}}, s_bit, imm};

  always_ff @(posedge clk) begin
    if (!rst_n)   acc <= '0;
    else if (hit) acc <= acc_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en   <= do_wr;
      wr_idx  <= do_wr ? dst : '0;
      wr_data <= do_wr ? acc_nx : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_data  <= '0;
    end else begin
      fwd_valid <= do_wr;
      fwd_data  <= do_wr ? acc_nx : '0;
    end
  end

  // R6
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && dst != '0) |=> (wr_en && wr_idx == $past(dst)));
  // R5
  r0_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && dst == '0) |=> !wr_en);
  // R7
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> (!wr_en && wr_data == '0));
  // R7
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(acc));
  // R4
  partial_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && is_p) |=> acc[IMM_W-1:0] == $past(imm));
  // R3
  full_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !is_p) |=> acc[DATA_W-1] == $past(s_bit));
  // R8
  fwd_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid == wr_en) && (fwd_data == wr_data));
endmodule

// File: tb/const_accum_decoder_tb.sv
module const_accum_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic [31:0] insn = '0;
  logic        wr_en, fwd_valid;
  logic [5:0]  wr_idx;
  logic [63:0] wr_data, fwd_data;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  const_accum_decoder dut_i (.clk(clk), .rst_n(rst_n), .insn_valid(insn_valid),
    .insn(insn), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data));

  // R2 field layout
  function automatic logic [31:0] mk(input logic [7:0] op, input logic p,
      input logic s, input logic [15:0] imm, input logic [5:0] d);
    return {op, p, s, imm, d};
  endfunction

  typedef struct packed {
    logic        v;
    logic [31:0] w;
    logic        en;
    logic [5:0]  idx;
    logic [63:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b1, mk(8'hC5,1,0,16'hABCD,5),  1'b1, 6'd5,  64'h000000000000ABCD, 8'd1},
    '{1'b1, mk(8'hC5,0,1,16'h0001,7),  1'b1, 6'd7,  64'hFFFFFFFFFFFF0001, 8'd3},
    '{1'b1, mk(8'hC5,1,1,16'h1234,9),  1'b1, 6'd9,  64'hFFFFFFFF00011234, 8'd4},
    '{1'b1, mk(8'h12,0,0,16'h1111,9),  1'b0, 6'd0,  64'h0,                8'd7},
    '{1'b1, mk(8'hC5,1,0,16'h5678,0),  1'b0, 6'd0,  64'h0,                8'd5},
    '{1'b0, mk(8'hC5,0,0,16'h0001,3),  1'b0, 6'd0,  64'h0,                8'd7},
    '{1'b1, mk(8'hC5,1,0,16'h9ABC,63), 1'b1, 6'd63, 64'h0001123456789ABC, 8'd9},
    '{1'b1, mk(8'hC5,0,0,16'hFFFF,1),  1'b1, 6'd1,  64'h000000000000FFFF, 8'd3},
    '{1'b1, mk(8'hC5,0,1,16'hFFFF,2),  1'b1, 6'd2,  64'hFFFFFFFFFFFFFFFF, 8'd3},
    '{1'b1, mk(8'hC5,1,0,16'h0000,4),  1'b1, 6'd4,  64'hFFFFFFFFFFFF0000, 8'd6}
  };

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [31:0] w);
    @(negedge clk);
    insn_valid = v;
    insn = w;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(5 * 5000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int nwr;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(!wr_en && !fwd_valid && wr_data == 0 && fwd_data == 0, "R1",
        {63'd0, wr_en}, 64'd0);
    @(negedge clk) rst_n = 1'b1;

    // R9 table applied back to back
    foreach (VECS[i]) begin
      issue(VECS[i].v, VECS[i].w);
      chk(wr_en == VECS[i].en && wr_idx == VECS[i].idx && wr_data == VECS[i].data,
          $sformatf("R%0d/R6/R9 vec%0d", VECS[i].req, i), wr_data, VECS[i].data);
      // R8
      chk(fwd_valid == wr_en && fwd_data == wr_data, "R8", fwd_data, wr_data);
    end
    issue(1'b0, '0);
    chk(!wr_en, "R6 single pulse", {63'd0, wr_en}, 64'd0);

    // R10 example sequence with unrelated word interleaved
    nwr = 0;
    issue(1'b1, mk(8'hC5,0,0,16'h7777,0)); nwr += wr_en;
    issue(1'b1, mk(8'h40,1,1,16'hDEAD,42)); nwr += wr_en;
    issue(1'b1, mk(8'hC5,1,0,16'h33BB,0)); nwr += wr_en;
    issue(1'b1, mk(8'hC5,1,0,16'h1919,42)); nwr += wr_en;
    chk(wr_en && wr_idx == 42 && wr_data == 64'h0000777733BB1919, "R10",
        wr_data, 64'h0000777733BB1919);
    issue(1'b0, '0); nwr += wr_en;
    chk(nwr == 1, "R10 write count", nwr, 1);

    // R1 mid-run reset clears accumulator
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk); #1;
    chk(!wr_en && wr_data == 0, "R1 reset outputs", wr_data, 0);
    @(negedge clk) rst_n = 1'b1;
    issue(1'b1, mk(8'hC5,1,1,16'h0042,3));
    chk(wr_en && wr_idx == 3 && wr_data == 64'h42, "R1 acc cleared", wr_data, 64'h42);
    issue(1'b0, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule